// File: doc/BRIEF.md
# Barrel Shifter with Carry Flag

This block shifts a 32-bit operand left logically, right logically or right arithmetically by an amount from 0 to 31 and returns the shifted word together with four condition flags: zero, sign, carry and overflow. The amount is taken either from a small unsigned immediate field or from the least significant five bits of a full-width register value; the remaining register bits play no part. Carry holds the last bit that left the word during the shift, and overflow is always driven low.

The datapath is a logarithmic tree of conditional shift stages. The same right-shifting tree serves left shifts by mirroring the operand on the way in and the result on the way out. One spare bit below the word catches the outgoing bit, so the carry comes out of the tree with no separate selector. A request presented with `in_valid` high is answered one clock later with `out_valid` high. While no request is presented, the outputs keep their last values.

Top module: `barrel_shift_unit`

## Requirements
- R1: With `in_kind` = 2'b00 the result is the operand shifted left by n, with zeros entering at bit 0.
- R2: With `in_kind` = 2'b01 the result is the operand shifted right by n, with zeros entering at bit 31.
- R3: With `in_kind` = 2'b10 or 2'b11 the result is the operand shifted right by n, with copies of operand bit 31 entering at the top.
- R4: With `in_src_reg` = 0 the amount n is `in_imm` read as an unsigned 5-bit value. With `in_src_reg` = 1, n is bits 4:0 of `in_reg_amt`, and bits 31:5 of `in_reg_amt` have no effect on any output.
- R5: For a right shift (logical or arithmetic) by n between 1 and 31, carry equals operand bit n-1.
- R6: For a left shift by n between 1 and 31, carry equals operand bit 32-n.
- R7: For n = 0 and any kind, the result equals the operand and carry is 0.
- R8: Zero is 1 exactly when the result is all zeros, and sign equals result bit 31.
- R9: Overflow is 0 after every shift and after reset.
- R10: A request taken with `in_valid` high appears on the outputs one clock later with `out_valid` high. In a cycle with `in_valid` low, `out_valid` falls and the result and flags keep their previous values.
- R11: While `rst_n` is low, `out_valid`, the result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | 00 left logical, 01 right logical, 1x right arithmetic |
| in_src_reg | input | 1 | 0 selects the immediate amount, 1 selects the register amount |
| in_operand | input | 32 | Word to be shifted |
| in_imm | input | 5 | Unsigned immediate amount |
| in_reg_amt | input | 32 | Register value whose low 5 bits give the amount |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_result | output | 32 | Shifted word |
| out_zero | output | 1 | Result is all zeros |
| out_sign | output | 1 | Result bit 31 |
| out_carry | output | 1 | Last bit shifted out, 0 for a zero amount |
| out_overflow | output | 1 | Always 0 |

## Verification
The bench builds the block with its default 32-bit width, so the amount space has only 32 values. For each operand in the set, this allows a full sweep over every amount, all four kind codes and both amount sources. The operand set holds the edge words 0x80000000, 0xFFFFFFFF, 0, 1 and 0x7FFFFFFF, an alternating pattern, and pseudo-random words. The register-sourced runs put nonzero values in the upper register bits, to show that those bits have no effect. After each request, the bench changes the inputs in an idle cycle and checks that the outputs keep their values.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;

  // Shift kind; bit 1 set means arithmetic right
  typedef enum logic [1:0] {
    KIND_LEFT      = 2'b00,
    KIND_RIGHT_LOG = 2'b01,
    KIND_RIGHT_ARI = 2'b10,
    KIND_RIGHT_AR2 = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic overflow;
  } shift_flags_t;

  // Left shifts run through the right-shifting tree mirrored
  function automatic logic kind_is_left(input logic [1:0] kind);
    return kind == KIND_LEFT;
  endfunction

  // Sign fill only for arithmetic right shifts
  function automatic logic kind_fills_sign(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/bsh_amount_sel.sv
module bsh_amount_sel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic              src_reg,
  input  logic [AMT_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_val,
  output logic [AMT_W-1:0]  amount
);

  // Only the low AMT_W register bits matter; the rest are dropped here
  logic [AMT_W-1:0] reg_low;
  assign reg_low = reg_val[AMT_W-1:0];

  always_comb begin
    if (src_reg) amount = reg_low;
    else         amount = imm;
  end

endmodule

// File: rtl/bsh_stage.sv
module bsh_stage #(
  parameter int W    = 33,
  parameter int DIST = 1
) (
  input  logic         en,
  input  logic         fill,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] moved;
  assign moved = {{DIST{fill}}, din[W-1:DIST]};

  always_comb begin
    if (en) dout = moved;
    else    dout = din;
  end

endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import barrel_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  output logic [DATA_W-1:0] result,
  output logic              carry
);

  localparam int EXT_W = DATA_W + 1;

  logic              go_left;
  logic              fill_bit;
  logic [DATA_W-1:0] op_mirror;
  logic [DATA_W-1:0] res_mirror;
  logic [DATA_W-1:0] tree_word;
  logic [DATA_W-1:0] tree_in_word;
  logic [EXT_W-1:0]  lane [AMT_W+1];

  assign go_left  = kind_is_left(kind);
  assign fill_bit = kind_fills_sign(kind) & operand[DATA_W-1];

  // Bit mirrors for the left path
  for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
    assign op_mirror[b]  = operand[DATA_W-1-b];
    assign res_mirror[b] = tree_word[DATA_W-1-b];
  end

  assign tree_in_word = go_left ? op_mirror : operand;

  // A spare bit below the word collects the last bit pushed out
  assign lane[0] = {tree_in_word, 1'b0};

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    bsh_stage #(.W(EXT_W), .DIST(1 << k)) u_stage (
      .en   (amount[k]),
      .fill (fill_bit),
      .din  (lane[k]),
      .dout (lane[k+1])
    );
  end

  assign tree_word = lane[AMT_W][EXT_W-1:1];
  assign carry     = lane[AMT_W][0];
  assign result    = go_left ? res_mirror : tree_word;

endmodule

// File: rtl/bsh_flags.sv
module bsh_flags
  import barrel_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  output shift_flags_t      flags
);

  always_comb begin
    flags.zero     = ~|result;
    flags.sign     = result[DATA_W-1];
    flags.carry    = carry;
    flags.overflow = 1'b0;
  end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import barrel_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic              in_src_reg,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [AMT_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_reg_amt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_sign,
  output logic              out_carry,
  output logic              out_overflow
);

  // Named internal events for the checker
  logic [AMT_W-1:0]  amt_sel;
  logic [DATA_W-1:0] core_result;
  logic              core_carry;
  shift_flags_t      core_flags;

  bsh_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .src_reg (in_src_reg),
    .imm     (in_imm),
    .reg_val (in_reg_amt),
    .amount  (amt_sel)
  );

  bsh_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .kind    (in_kind),
    .operand (in_operand),
    .amount  (amt_sel),
    .result  (core_result),
    .carry   (core_carry)
  );

  bsh_flags #(.DATA_W(DATA_W)) u_flags (
    .result (core_result),
    .carry  (core_carry),
    .flags  (core_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_zero     <= 1'b0;
      out_sign     <= 1'b0;
      out_carry    <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= core_result;
        out_zero     <= core_flags.zero;
        out_sign     <= core_flags.sign;
        out_carry    <= core_flags.carry;
        out_overflow <= core_flags.overflow;
      end
    end
  end

endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_kind,
  input logic [DATA_W-1:0] in_operand,
  input logic [AMT_W-1:0]  amt_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_zero,
  input logic              out_sign,
  input logic              out_carry,
  input logic              out_overflow
);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_overflow);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_carry) && $stable(out_zero));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result == '0));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sign == out_result[DATA_W-1]);

  assert_zero_amount_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amt_sel == '0) |=> (out_result == $past(in_operand)) && !out_carry);

  assert_sar_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind[1]) |=> out_result[DATA_W-1] == $past(in_operand[DATA_W-1]));

  assert_shl_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b00 && amt_sel != '0) |=> !out_result[0]);

endmodule

bind barrel_shift_unit bsh_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_kind      (in_kind),
  .in_operand   (in_operand),
  .amt_sel      (amt_sel),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_zero     (out_zero),
  .out_sign     (out_sign),
  .out_carry    (out_carry),
  .out_overflow (out_overflow)
);

// File: tb/sim_barrel_shift_unit.sv
`timescale 1ns/1ps
module sim_barrel_shift_unit;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_kind = 2'b00;
  logic          in_src_reg = 1'b0;
  logic [W-1:0]  in_operand = '0;
  logic [4:0]    in_imm = '0;
  logic [W-1:0]  in_reg_amt = '0;
  logic          out_valid;
  logic [W-1:0]  out_result;
  logic          out_zero, out_sign, out_carry, out_overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1d872b41;

  always #5 clk = ~clk;

  barrel_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_src_reg(in_src_reg), .in_operand(in_operand), .in_imm(in_imm),
    .in_reg_amt(in_reg_amt), .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_sign(out_sign), .out_carry(out_carry),
    .out_overflow(out_overflow)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] kind, input bit src, input logic [31:0] op,
                         input int n, input logic [26:0] upper);
    logic [31:0] exp_res;
    logic        exp_cy;
    logic [31:0] held;
    string       rtag, ctag;
    if (kind == 2'b00) begin
      exp_res = op << n;
      exp_cy  = (n == 0) ? 1'b0 : op[32-n];
      rtag = "R1"; ctag = "R6";
    end else if (kind == 2'b01) begin
      exp_res = op >> n;
      exp_cy  = (n == 0) ? 1'b0 : op[n-1];
      rtag = "R2"; ctag = "R5";
    end else begin
      exp_res = $unsigned($signed(op) >>> n);
      exp_cy  = (n == 0) ? 1'b0 : op[n-1];
      rtag = "R3"; ctag = "R5";
    end
    if (n == 0) begin rtag = "R7"; ctag = "R7"; end
    if (src) rtag = {rtag, "/R4"};
    @(negedge clk);
    in_valid   = 1'b1;
    in_kind    = kind;
    in_src_reg = src;
    in_operand = op;
    in_imm     = src ? 5'(~n) : 5'(n);
    in_reg_amt = src ? {upper, 5'(n)} : {upper, 5'(~n)};
    @(negedge clk);
    in_valid = 1'b0;
    check(rtag, out_result, exp_res);
    check(ctag, {31'd0, out_carry}, {31'd0, exp_cy});
    check("R8 zero", {31'd0, out_zero}, {31'd0, exp_res == 32'd0});
    check("R8 sign", {31'd0, out_sign}, {31'd0, exp_res[31]});
    check("R9", {31'd0, out_overflow}, 32'd0);
    check("R10 valid", {31'd0, out_valid}, 32'd1);
    held = out_result;
    in_operand = ~op;
    in_imm     = 5'(n + 3);
    in_reg_amt = ~in_reg_amt;
    in_kind    = kind ^ 2'b01;
    @(negedge clk);
    check("R10 hold", out_result, held);
    check("R10 hold carry", {31'd0, out_carry}, {31'd0, exp_cy});
    check("R10 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    logic [31:0] ops [12];
    ops[0] = 32'h8000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h0000_0000;
    ops[3] = 32'h0000_0001; ops[4] = 32'h7FFF_FFFF; ops[5] = 32'hA5A5_5A5A;
    for (int i = 6; i < 12; i++) begin
      lfsr = next_rand(next_rand(next_rand(lfsr)));
      ops[i] = lfsr;
    end
    // Reset state, R11
    in_operand = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 result", out_result, 32'd0);
    check("R11 flags", {28'd0, out_zero, out_sign, out_carry, out_overflow}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 12; i++)
          for (int n = 0; n < 32; n++) begin
            lfsr = next_rand(lfsr);
            run_one(2'(k), s[0], ops[i], n, s[0] ? (lfsr[26:0] | 27'h1) : lfsr[26:0]);
          end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule